// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a first-in first-out buffer of 64 words, each 5 bits wide. Two level strobes control it: a write strobe and a read strobe. A write is taken on the rising edge of the write strobe. The oldest stored word then moves on its own into an output register, once the write strobe has gone low again. A read discards the presented word on the falling edge of the read strobe, and the next word then moves forward.

Two handshake lines show the state at each end. The input-ready line says that a write can be taken. The output-ready line says that a valid word is waiting at the output. Two occupancy flags show the fill level. One flag is high near either end of the range, so it covers both almost-full and almost-empty. The other flag shows that the buffer is at least half full.

Both strobes come from outside the system clock domain. Each strobe passes through a two-flop synchronizer, and edge detection works on the synchronized value. Every strobe event therefore takes effect at a fixed number of clock edges after the strobe changes. The block also handles two automatic transfer cases. A word written into an empty buffer while the read strobe is held high still reaches the output. A write that is held while the buffer is full is taken as soon as a read frees a slot.

Top module: `fall_fifo`

## Requirements
- R1: A word on `din` is stored on a synchronized rising edge of `shift_in` if fewer than 64 words are held. When the buffer holds words and nothing is presented, the oldest word is loaded into `dout` while `shift_in` is low.
- R2: A synchronized falling edge of `shift_out` removes the presented word. The next word then moves to `dout`. Words leave in the order they were written.
- R3: A `shift_in` pulse while 64 words are held stores nothing. A `shift_out` pulse while the buffer is empty changes neither `dout` nor any flag.
- R4: When the last word is removed, `dout` keeps its value. It changes only when a new word falls through or reset is applied.
- R5: `out_rdy` is high when a word is presented and `shift_out` is low. It is low while `shift_out` is high, and low while the buffer is empty.
- R6: `in_rdy` is high when fewer than 64 words are held and `shift_in` is low. It is low while `shift_in` is high, and low while the buffer holds 64 words.
- R7: `almost_flag` is high when the count is 8 or less, or 56 or more. It is low for counts 9 to 55. The count includes the presented word.
- R8: `half_flag` is high when the count is 32 or more, and low when it is 31 or less.
- R9: Suppose the buffer is empty and `shift_out` is held high. A word that is then written is still loaded into `dout`, and `out_rdy` is high for exactly one clock cycle.
- R10: Suppose the buffer is full and `shift_in` is held high. A falling edge of `shift_out` frees a slot. `in_rdy` is then high for exactly one clock cycle, and the held `din` word is stored without a new rising edge.
- R11: Synchronous active-high `rst` empties the buffer and clears `dout` to zero. It sets `out_rdy` low, `in_rdy` high, `almost_flag` high and `half_flag` low.
- R12: A change on `shift_in` or `shift_out` made between clock edges shows at the outputs on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both strobes are sampled on it |
| rst | input | 1 | Synchronous reset, active high |
| shift_in | input | 1 | Write strobe, level; the rising edge stores a word |
| shift_out | input | 1 | Read strobe, level; the falling edge removes the presented word |
| din | input | 5 | Write data; held stable while `shift_in` is high |
| dout | output | 5 | Presented word |
| out_rdy | output | 1 | A valid word is waiting on `dout` |
| in_rdy | output | 1 | A write can be accepted |
| almost_flag | output | 1 | Count is 8 or less, or 56 or more |
| half_flag | output | 1 | Count is 32 or more |

## Verification
Every strobe change is driven between clock edges. Its effect is registered on the third rising edge after it. A presented word is replaced one edge after a removal, so a new word shows on the fourth edge after `shift_out` falls. For table steps and fill steps, the bench waits four edges after a write and five edges after a read, then samples on a falling edge. In the latency test it samples after edges one, two and three and expects the change only after the third. The one-cycle pulses of R9 and R10 are checked by counting the high cycles of `out_rdy` and `in_rdy` over a window longer than the event. This makes the count independent of the exact edge on which the pulse lands.

// File: rtl/fall_fifo_pkg.sv
package fall_fifo_pkg;

    localparam int DATA_W     = 5;
    localparam int FIFO_DEPTH = 64;
    localparam int LOW_MARK   = 8;
    localparam int HIGH_MARK  = 56;

    // Synchronized strobe: level plus the one edge the consumer uses
    typedef struct packed {
        logic level;
        logic edge_ev;
    } strobe_t;

    function automatic logic near_end(input int count, input int lo, input int hi);
        return (count <= lo) || (count >= hi);
    endfunction

    function automatic logic at_least(input int count, input int mark);
        return count >= mark;
    endfunction

endpackage

// File: rtl/fall_fifo_sync.sv
module fall_fifo_sync
    import fall_fifo_pkg::*;
#(
    parameter bit RISING = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    strobe,
    output strobe_t ev
);

    // sh[0], sh[1]: two-flop synchronizer; sh[2]: previous synchronized value
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], strobe};
    end

    generate
        if (RISING) begin : g_rise
            always_comb begin
                ev.level   = sh[1];
                ev.edge_ev = sh[1] & ~sh[2];
            end
        end else begin : g_fall
            always_comb begin
                ev.level   = sh[1];
                ev.edge_ev = ~sh[1] & sh[2];
            end
        end
    endgenerate

endmodule

// File: rtl/fall_fifo_mem.sv
module fall_fifo_mem #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/fall_fifo_flags.sv
module fall_fifo_flags
    import fall_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LOW   = 8,
    parameter int HIGH  = 56,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count_next,
    output logic          almost_flag,
    output logic          half_flag
);

    localparam int HALF = DEPTH / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            almost_flag <= 1'b1;
            half_flag   <= 1'b0;
        end else begin
            almost_flag <= near_end(int'(count_next), LOW, HIGH);
            half_flag   <= at_least(int'(count_next), HALF);
        end
    end

endmodule

// File: rtl/fall_fifo.sv
module fall_fifo
    import fall_fifo_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int LOW   = LOW_MARK,
    parameter int HIGH  = HIGH_MARK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    input  logic             shift_out,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             out_rdy,
    output logic             in_rdy,
    output logic             almost_flag,
    output logic             half_flag
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    strobe_t si_ev, so_ev;

    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]    cnt_q, cnt_next;
    logic             present_q, present_next;
    logic             pend_q, pend_next;
    logic             full, wr_now, remove, load;
    logic [WIDTH-1:0] head_word;

    fall_fifo_sync #(.RISING(1'b1)) u_si_sync (
        .clk(clk), .rst(rst), .strobe(shift_in), .ev(si_ev)
    );

    fall_fifo_sync #(.RISING(1'b0)) u_so_sync (
        .clk(clk), .rst(rst), .strobe(shift_out), .ev(so_ev)
    );

    fall_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(wr_now), .waddr(wr_ptr_q), .wdata(din),
        .raddr(rd_ptr_q), .rdata(head_word)
    );

    fall_fifo_flags #(.DEPTH(DEPTH), .LOW(LOW), .HIGH(HIGH)) u_flags (
        .clk(clk), .rst(rst), .count_next(cnt_next),
        .almost_flag(almost_flag), .half_flag(half_flag)
    );

    always_comb begin
        full   = (cnt_q == FULL_CNT);
        // A held write (pend_q) is taken once a slot has been freed
        wr_now = (si_ev.edge_ev | (pend_q & si_ev.level)) & ~full;
        remove = so_ev.edge_ev & present_q;
        load   = ~present_q & (cnt_q != '0) & ~si_ev.level;

        cnt_next     = cnt_q + CW'(wr_now) - CW'(remove);
        present_next = load | (present_q & ~remove);

        if (!si_ev.level)                  pend_next = 1'b0;
        else if (si_ev.edge_ev && full)    pend_next = 1'b1;
        else if (wr_now)                   pend_next = 1'b0;
        else                               pend_next = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q  <= '0;
            rd_ptr_q  <= '0;
            cnt_q     <= '0;
            present_q <= 1'b0;
            pend_q    <= 1'b0;
            dout      <= '0;
            out_rdy   <= 1'b0;
            in_rdy    <= 1'b1;
        end else begin
            cnt_q     <= cnt_next;
            present_q <= present_next;
            pend_q    <= pend_next;
            if (wr_now) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (remove) rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            if (load)   dout     <= head_word;
            out_rdy <= load | (present_next & ~so_ev.level);
            in_rdy  <= (cnt_next != FULL_CNT) & (~si_ev.level | pend_next);
        end
    end

endmodule

// File: rtl/fall_fifo_chk.sv
module fall_fifo_chk #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64,
    parameter int LOW   = 8,
    parameter int HIGH  = 56,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [CW-1:0]    count,
    input logic [WIDTH-1:0] dout,
    input logic             out_rdy,
    input logic             in_rdy,
    input logic             almost_flag,
    input logic             half_flag
);

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1) ||
        (count + 1'b1 == $past(count)));

    // R7
    almost_level_chk: assert property (@(posedge clk) disable iff (rst)
        almost_flag == ((count <= CW'(LOW)) || (count >= CW'(HIGH))));

    // R8
    half_level_chk: assert property (@(posedge clk) disable iff (rst)
        half_flag == (count >= CW'(DEPTH / 2)));

    // R5
    empty_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !out_rdy);

    // R6
    full_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |-> !in_rdy);

    // R4
    hold_last_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0) && ($past(count) == '0) |-> $stable(dout));

endmodule

bind fall_fifo fall_fifo_chk #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .LOW(LOW), .HIGH(HIGH)
) u_chk (
    .clk(clk), .rst(rst), .count(cnt_q), .dout(dout), .out_rdy(out_rdy),
    .in_rdy(in_rdy), .almost_flag(almost_flag), .half_flag(half_flag)
);

// File: tb/fall_fifo_tb.sv
module fall_fifo_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_in = 1'b0;
    logic       shift_out = 1'b0;
    logic [4:0] din = '0;
    logic [4:0] dout;
    logic       out_rdy, in_rdy, almost_flag, half_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fall_fifo u_dut (
        .clk(clk), .rst(rst), .shift_in(shift_in), .shift_out(shift_out),
        .din(din), .dout(dout), .out_rdy(out_rdy), .in_rdy(in_rdy),
        .almost_flag(almost_flag), .half_flag(half_flag)
    );

    // Vector: [14] op (1 = read), [13:9] write data, [8:4] expected dout,
    //         [3] out_rdy, [2] in_rdy, [1] almost_flag, [0] half_flag
    localparam int NVEC = 9;
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 5'h0A, 5'h0A, 4'b1110},
        {1'b0, 5'h15, 5'h0A, 4'b1110},
        {1'b0, 5'h03, 5'h0A, 4'b1110},
        {1'b1, 5'h00, 5'h15, 4'b1110},
        {1'b1, 5'h00, 5'h03, 4'b1110},
        {1'b1, 5'h00, 5'h03, 4'b0110},
        {1'b1, 5'h00, 5'h03, 4'b0110},
        {1'b0, 5'h1F, 5'h1F, 4'b1110},
        {1'b1, 5'h00, 5'h1F, 4'b0110}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [4:0] d);
        din = d;
        shift_in = 1'b1;
        cyc(4);
        shift_in = 1'b0;
        cyc(4);
    endtask

    task automatic pop();
        shift_out = 1'b1;
        cyc(4);
        shift_out = 1'b0;
        cyc(5);
    endtask

    function automatic logic [4:0] status();
        return {out_rdy, in_rdy, almost_flag, half_flag, 1'b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ones;
        cyc(4);
        rst = 1'b0;
        cyc(1);

        // R11 reset state
        check({dout, out_rdy, in_rdy, almost_flag, half_flag} == {5'h00, 4'b0110},
              "R11 reset", {dout, out_rdy, in_rdy, almost_flag, half_flag}, {5'h00, 4'b0110});

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][14]) pop();
            else            push(VEC[i][13:9]);
            check({dout, out_rdy, in_rdy, almost_flag, half_flag} == VEC[i][8:0],
                  $sformatf("R1 R2 R3 R4 vector %0d", i),
                  {dout, out_rdy, in_rdy, almost_flag, half_flag}, VEC[i][8:0]);
        end

        // R12 latency: write strobe takes effect on the third edge
        din = 5'h11;
        shift_in = 1'b1;
        for (int e = 1; e <= 3; e++) begin
            cyc(1);
            check(in_rdy == (e < 3), "R12 in_rdy latency", in_rdy, (e < 3));
        end
        shift_in = 1'b0;
        for (int e = 1; e <= 3; e++) begin
            cyc(1);
            check(out_rdy == (e == 3), "R12 out_rdy latency", out_rdy, (e == 3));
        end
        check(dout == 5'h11, "R12 R1 fall-through data", dout, 5'h11);
        cyc(2);
        pop();

        // R7 R8 thresholds while filling from empty
        for (int k = 1; k <= 64; k++) begin
            logic [1:0] exp_fl;
            push(5'(k));
            exp_fl = {(k <= 8) || (k >= 56), k >= 32};
            check({almost_flag, half_flag} == exp_fl,
                  $sformatf("R7 R8 count %0d", k), {almost_flag, half_flag}, exp_fl);
        end
        check(in_rdy == 1'b0, "R6 full", in_rdy, 0);
        check(dout == 5'h01, "R1 head word", dout, 5'h01);

        // R3 write while full is ignored
        push(5'h1B);
        check({in_rdy, almost_flag, half_flag, out_rdy} == 4'b0111,
              "R3 full write", {in_rdy, almost_flag, half_flag, out_rdy}, 4'b0111);

        // R10 held write is taken once a read frees a slot
        din = 5'h15;
        shift_in = 1'b1;
        cyc(4);
        check(in_rdy == 1'b0, "R6 in_rdy low while full", in_rdy, 0);
        shift_out = 1'b1;
        cyc(4);
        shift_out = 1'b0;
        ones = 0;
        for (int c = 0; c < 10; c++) begin
            cyc(1);
            if (in_rdy) ones++;
        end
        check(ones == 1, "R10 in_rdy pulse", ones, 1);
        shift_in = 1'b0;
        cyc(5);
        check({in_rdy, half_flag} == 2'b01, "R10 refilled", {in_rdy, half_flag}, 2'b01);

        // R2 order: words 2..64, then the held word
        for (int j = 2; j <= 64; j++) begin
            check(dout == 5'(j) && out_rdy, $sformatf("R2 order %0d", j), dout, 5'(j));
            pop();
        end
        check(dout == 5'h15 && out_rdy, "R10 held word stored", dout, 5'h15);
        pop();
        // R3 R4: nothing beyond 64 words, last word held
        check({dout, out_rdy, in_rdy, almost_flag, half_flag} == {5'h15, 4'b0110},
              "R3 R4 drained", {dout, out_rdy, in_rdy, almost_flag, half_flag}, {5'h15, 4'b0110});

        // R9 write into empty buffer while read strobe held high
        shift_out = 1'b1;
        cyc(4);
        din = 5'h0C;
        shift_in = 1'b1;
        cyc(4);
        shift_in = 1'b0;
        ones = 0;
        for (int c = 0; c < 8; c++) begin
            cyc(1);
            if (out_rdy) ones++;
        end
        check(ones == 1, "R9 out_rdy pulse", ones, 1);
        check(dout == 5'h0C, "R9 word reaches output", dout, 5'h0C);
        shift_out = 1'b0;
        cyc(5);
        check({dout, out_rdy, almost_flag, half_flag} == {5'h0C, 3'b010},
              "R9 R4 removed", {dout, out_rdy, almost_flag, half_flag}, {5'h0C, 3'b010});

        // R11 reset while holding a word
        push(5'h07);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        check({dout, out_rdy, in_rdy, almost_flag, half_flag} == {5'h00, 4'b0110},
              "R11 reset with data", {dout, out_rdy, in_rdy, almost_flag, half_flag}, {5'h00, 4'b0110});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule